// File: doc/BRIEF.md
# Multi-mode scannable state register

This block stands in for the plain state flip-flops of a sequential circuit. The surrounding next-state logic is not touched. The block holds two registers of the same width.

- **State register.** It captures the next-state vector in normal operation. In scan operation it becomes a serial chain from `scanIn` to `scanOut`, which loads and unloads state.
- **Signature register.** It works as a multiple-input signature register. On each clock of a compaction mode it folds the incoming next-state vector into its shifted, feedback-modified contents. The circuit keeps running with its true captured state while this happens, so the final signature stands for every state the logic produced and no state has to be scanned out after each pattern.

In generator mode the signature register contents drive the state outputs. The logic then receives a fresh pseudorandom state on every clock (test-per-clock). Two consecutive patterns are launched on back-to-back edges along the normally active paths, which is the stimulus a two-pattern delay test needs.

The feedback is a fixed Galois-form tap mask `TAPS`. Its default is x^8+x^4+x^3+x^2+1, which is primitive. A synchronous reset loads both registers with a non-zero `SEED`, so a generator run that starts from reset can never fall into the all-zero state.

Top module: `scan_state_reg`

## Requirements
- R1: While `rst` is high at a rising edge, both registers load `SEED` and the output select returns to the state register. After that edge, `state` = `SEED`, `signature` = `SEED` and `scanOut` = `SEED[WIDTH-1]`. Reset takes priority over every mode.
- R2: Mode 2'b00 (capture) loads `nextState` into the state register at each edge and leaves the signature register unchanged.
- R3: Mode 2'b01 (shift) moves the state register one place toward the MSB at each edge and enters `scanIn` at bit 0. `scanOut` always equals the state register MSB. A full unload of WIDTH bits, MSB first, takes exactly WIDTH edges. The signature register holds during shift.
- R4: Modes 2'b10 and 2'b11 update the signature register at each edge to `({sig[WIDTH-2:0],1'b0} ^ (sig[WIDTH-1] ? TAPS : 0)) ^ nextState`.
- R5: In mode 2'b10 the state register still captures `nextState`, and `state` shows that captured value.
- R6: In mode 2'b11 the state register still captures `nextState`, but `state` shows the signature register. The output select follows the mode sampled at the previous edge, so a mode change takes effect at the next rising edge.
- R7: In mode 2'b11 with `nextState` held at zero, the signature register never becomes zero. With the default parameters it returns to `SEED` after exactly 255 edges and not before.
- R8: A single-bit change in any one next-state vector during compaction changes the final signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to SEED |
| mode | input | 2 | 00 capture, 01 shift, 10 compact, 11 generate |
| nextState | input | WIDTH | Next-state vector from the circuit logic |
| scanIn | input | 1 | Serial scan input into bit 0 |
| state | output | WIDTH | State presented to the circuit logic |
| scanOut | output | 1 | Serial scan output, state register MSB |
| signature | output | WIDTH | Signature register read-out |

## Verification
The bench builds the block with its defaults: WIDTH = 8, TAPS = 8'h1D and SEED = 8'h01. At eight bits a generator run with a zero input covers the full 255-state period in a few hundred clocks, so both the non-zero property and the exact return to the seed can be observed directly.

The same width also makes it cheap to flip each of the eight next-state bits, one per trial, in a compaction run and to compare every corrupted signature with the clean one. Random mode sequences with occasional resets then exercise every mode transition against a bench model of both registers and of the output select.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    MODE_CAPTURE  = 2'b00,
    MODE_SHIFT    = 2'b01,
    MODE_COMPACT  = 2'b10,
    MODE_GENERATE = 2'b11
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic capEn;
    logic shiftEn;
    logic sigEn;
    logic showSig;
  } ctlStrobesT;

endpackage

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  output ctlStrobesT strobes
);

  modeT modeSel;
  logic showSigQ;

  assign modeSel = modeT'(mode);

  // output select is registered so a mode change lands on the next edge
  always_ff @(posedge clk) begin
    if (rst) showSigQ <= 1'b0;
    else     showSigQ <= (modeSel == MODE_GENERATE);
  end

  always_comb begin
    strobes         = '0;
    strobes.showSig = showSigQ;
    unique case (modeSel)
      MODE_CAPTURE:  strobes.capEn   = 1'b1;
      MODE_SHIFT:    strobes.shiftEn = 1'b1;
      MODE_COMPACT: begin
        strobes.capEn = 1'b1;
        strobes.sigEn = 1'b1;
      end
      MODE_GENERATE: begin
        strobes.capEn = 1'b1;
        strobes.sigEn = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/ssr_datapath.sv
module ssr_datapath
  import ssr_pkg::*;
#(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'h1D,
  parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobesT       strobes,
  input  logic [WIDTH-1:0] nextState,
  input  logic             scanIn,
  output logic [WIDTH-1:0] state,
  output logic             scanOut,
  output logic [WIDTH-1:0] signature
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] stateReg;
  logic [WIDTH-1:0] sigReg;
  logic [WIDTH-1:0] sigNext;
  logic             feedBit;

  assign feedBit = sigReg[MSB];

  // Galois-form signature update, one bit slice per stage
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_lsb
      assign sigNext[i] = (feedBit & TAPS[i]) ^ nextState[i];
    end else begin : g_upper
      assign sigNext[i] = sigReg[i-1] ^ (feedBit & TAPS[i]) ^ nextState[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateReg <= SEED;
    end else if (strobes.shiftEn) begin
      stateReg <= {stateReg[MSB-1:0], scanIn};
    end else if (strobes.capEn) begin
      stateReg <= nextState;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                sigReg <= SEED;
    else if (strobes.sigEn) sigReg <= sigNext;
  end

  assign state     = strobes.showSig ? sigReg : stateReg;
  assign scanOut   = stateReg[MSB];
  assign signature = sigReg;

endmodule

// File: rtl/scan_state_reg.sv
module scan_state_reg
  import ssr_pkg::*;
#(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'h1D,
  parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] nextState,
  input  logic             scanIn,
  output logic [WIDTH-1:0] state,
  output logic             scanOut,
  output logic [WIDTH-1:0] signature
);

  ctlStrobesT strobes;

  ssr_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .strobes (strobes)
  );

  ssr_datapath #(
    .WIDTH (WIDTH),
    .TAPS  (TAPS),
    .SEED  (SEED)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .nextState (nextState),
    .scanIn    (scanIn),
    .state     (state),
    .scanOut   (scanOut),
    .signature (signature)
  );

endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'h1D,
  parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] nextState,
  input logic             scanIn,
  input logic [WIDTH-1:0] state,
  input logic             scanOut,
  input logic [WIDTH-1:0] signature
);

  function automatic logic [WIDTH-1:0] foldIn(input logic [WIDTH-1:0] s,
                                              input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] t;
    t = s << 1;
    if (s[WIDTH-1]) t = t ^ TAPS;
    return t ^ v;
  endfunction

  // R1
  a_r1_reset_seed: assert property (@(posedge clk)
    rst |=> (state == SEED && signature == SEED));

  // R2
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (state == $past(nextState) && signature == $past(signature)));

  // R3
  a_r3_shift: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && $past(mode) != 2'b11)
      |=> (state == {$past(state[WIDTH-2:0]), $past(scanIn)} && $stable(signature)));

  // R3
  a_r3_scanout_msb: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) != 2'b11) |-> (scanOut == state[WIDTH-1]));

  // R4
  a_r4_fold: assert property (@(posedge clk) disable iff (rst)
    mode[1] |=> (signature == foldIn($past(signature), $past(nextState))));

  // R5
  a_r5_compact_state: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> (state == $past(nextState)));

  // R6
  a_r6_generate_out: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (state == signature));

  // R7
  a_r7_never_zero: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && nextState == '0 && signature != '0) |=> (signature != '0));

endmodule

bind scan_state_reg ssr_checker #(
  .WIDTH (WIDTH),
  .TAPS  (TAPS),
  .SEED  (SEED)
) u_ssr_checker (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .nextState (nextState),
  .scanIn    (scanIn),
  .state     (state),
  .scanOut   (scanOut),
  .signature (signature)
);

// File: tb/scan_state_reg_bench.sv
`timescale 1ns/1ps
module scan_state_reg_bench;

  localparam int         W    = 8;
  localparam logic [7:0] TAPS = 8'h1D;
  localparam logic [7:0] SEED = 8'h01;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   mode;
  logic [W-1:0] nextState;
  logic         scanIn;
  logic [W-1:0] state;
  logic         scanOut;
  logic [W-1:0] signature;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  logic [W-1:0] mState, mSig;
  bit           mShow;

  always #4 clk = ~clk;

  scan_state_reg u_scan_state_reg (
    .clk(clk), .rst(rst), .mode(mode), .nextState(nextState),
    .scanIn(scanIn), .state(state), .scanOut(scanOut), .signature(signature)
  );

  function automatic logic [W-1:0] refFold(input logic [W-1:0] s, input logic [W-1:0] v);
    logic [W-1:0] t;
    t = {s[W-2:0], 1'b0};
    if (s[W-1]) t = t ^ TAPS;
    return t ^ v;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, advance one edge, update model, sample at next negedge
  task automatic step(input bit r, input logic [1:0] m, input logic [W-1:0] d, input bit si);
    rst = r; mode = m; nextState = d; scanIn = si;
    @(negedge clk);
    if (r) begin
      mState = SEED; mSig = SEED; mShow = 0;
    end else begin
      case (m)
        2'b00: mState = d;
        2'b01: mState = {mState[W-2:0], si};
        default: begin mSig = refFold(mSig, d); mState = d; end
      endcase
      mShow = (m == 2'b11);
    end
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " state"}, state, mShow ? mSig : mState);
    chk({tag, " signature"}, signature, mSig);
    chk({tag, " scanOut"}, {7'b0, scanOut}, {7'b0, mState[W-1]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pat, unl, cleanSig;
    logic [W-1:0] vecs [40];
    bit neverZero;
    int period;
    void'($urandom(32'd4242));
    rst = 1; mode = 0; nextState = 0; scanIn = 0;
    @(negedge clk);

    // R1 reset state, reset overrides generate mode
    step(1, 2'b11, 8'hA5, 1'b1);
    chk("R1 state", state, SEED);
    chk("R1 signature", signature, SEED);
    chk("R1 scanOut", {7'b0, scanOut}, {7'b0, SEED[W-1]});

    // R2 capture, signature holds
    step(0, 2'b00, 8'h3C, 0); checkAll("R2 cap1");
    step(0, 2'b00, 8'hC3, 0); checkAll("R2 cap2");

    // R3 load pattern serially, then unload MSB first in exactly W edges
    pat = 8'b1011_0010;
    for (int i = W-1; i >= 0; i--) step(0, 2'b01, 8'hFF, pat[i]);
    chk("R3 loaded", state, pat);
    chk("R3 sig held", signature, SEED);
    unl = '0;
    for (int i = 0; i < W; i++) begin
      unl = {unl[W-2:0], scanOut};
      step(0, 2'b01, 8'h00, 1'b0);
    end
    chk("R3 unload", unl, pat);

    // R4 R5 compaction with captured state shown
    step(1, 2'b00, 0, 0);
    step(0, 2'b10, 8'h81, 0); checkAll("R4 R5 c1");
    step(0, 2'b10, 8'h7E, 0); checkAll("R4 R5 c2");

    // R6 mode change lands on next edge
    step(0, 2'b11, 8'h55, 0); checkAll("R6 gen1");
    chk("R6 shows sig", state, signature);
    step(0, 2'b00, 8'h99, 0); checkAll("R6 back");
    chk("R6 captured", state, 8'h99);

    // R7 full generator period with zero input
    step(1, 2'b00, 0, 0);
    neverZero = 1; period = 0;
    for (int i = 1; i <= 300; i++) begin
      step(0, 2'b11, 8'h00, 0);
      if (signature == '0) neverZero = 0;
      if (period == 0 && signature == SEED) period = i;
    end
    chk("R7 nonzero", {7'b0, neverZero}, 8'd1);
    chk("R7 period", period[7:0], 8'd255);

    // R8 single-bit error in compaction run
    for (int i = 0; i < 40; i++) vecs[i] = 8'($urandom);
    step(1, 2'b00, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 2'b10, vecs[i], 0);
    cleanSig = signature;
    chk("R8 clean vs model", cleanSig, mSig);
    for (int b = 0; b < W; b++) begin
      step(1, 2'b00, 0, 0);
      for (int i = 0; i < 40; i++)
        step(0, 2'b10, (i == 5*b + 3) ? (vecs[i] ^ (8'd1 << b)) : vecs[i], 0);
      checks++;
      if (signature == cleanSig) begin
        fails++;
        $display("FAIL R8 bit %0d actual=%h expected!=%h", b, signature, cleanSig);
      end
    end

    // random mix of all modes, R1..R6 against the model
    step(1, 2'b00, 0, 0);
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 50) == 0, 2'($urandom), 8'($urandom), 1'($urandom));
      checkAll("R1 R2 R3 R4 R5 R6 rand");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule